// File: doc/BRIEF.md
# Full-Map Directory Coherence Controller

This block is the central point of coherence for a group of processors that share one memory. For every memory block it keeps a directory record with a presence bit for each processor and a flag that marks the block as held by a single writer. Processors bring it two kinds of request over a valid/ready port: a read miss, or a request for exclusive (writable) ownership of a block. The controller answers each request with a one-cycle grant pulse. Before it can grant, it may first have to send commands to other processors' ports and wait for their replies.

An exclusive request sends an invalidate pulse to every processor whose presence bit is set, except the requester. The controller counts the acknowledgements that come back and grants only after the last one has arrived. A read miss to a block that another processor holds for writing sends a write-back command to that holder. Once the holder reports completion, the block becomes shared by the holder and the reader, and the read is granted. The controller serves one request at a time. It models memory traffic only as command and handshake pulses.

Top module: `fmap_dir_ctrl`

## Requirements
- R1: After reset every directory record is empty (no presence bits, not held for writing), `req_ready` is high, and no command or grant pulse is driven.
- R2: A read miss to a block not held for writing is granted (`grant_valid`=1, `grant_excl`=0) in the cycle after the request is accepted, with no command pulse, and the reader's presence bit is set.
- R3: An exclusive request to a block with presence bits set for other processors drives `cmd_inv` high for exactly those processors, for one cycle, in the cycle after acceptance, with `cmd_addr` equal to the block.
- R4: Exclusive access is granted (`grant_excl`=1) in the cycle after the last outstanding invalidate acknowledgement arrives and never earlier, whether the acknowledgements come one at a time or together.
- R5: After an exclusive grant, the block's record holds only the requester's presence bit and is marked as held for writing.
- R6: A read miss to a block held for writing by a different processor drives `cmd_wb` high for that holder only, for one cycle, in the cycle after acceptance.
- R7: In the cycle after the holder raises its `wb_done` bit, the read is granted as shared, and the record then holds the former holder and the reader, not marked for writing.
- R8: `req_ready` is low from the cycle after an invalidating or write-back request is accepted until its grant cycle, in which it is high again.
- R9: No invalidate is ever sent to the requester. An exclusive request where no other processor has a presence bit, including one where only the requester's bit is set, is granted in the cycle after acceptance.
- R10: A pulse on an `inv_ack` bit for a processor that is not awaiting invalidation is not counted and does not bring the grant forward.
- R11: A read miss from the processor that already holds the block for writing is granted in the cycle after acceptance without a command, and the block stays held for writing by it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_excl | input | 1 | 1 = exclusive ownership request, 0 = read miss |
| req_src | input | PID_W | Requesting processor index |
| req_addr | input | ADDR_W | Memory block index |
| cmd_inv | output | N_PROC | One-cycle invalidate pulse, one bit per processor |
| cmd_wb | output | N_PROC | One-cycle write-back pulse, one bit per processor |
| cmd_addr | output | ADDR_W | Block that the command pulses refer to |
| inv_ack | input | N_PROC | Invalidate acknowledgement, one bit per processor |
| wb_done | input | N_PROC | Write-back completion, one bit per processor |
| grant_valid | output | 1 | One-cycle grant pulse |
| grant_excl | output | 1 | Grant type: 1 = exclusive, 0 = shared read |
| grant_dst | output | PID_W | Processor that receives the grant |
| grant_addr | output | ADDR_W | Block that is granted |

## Verification
The assertions assume that each processor acknowledges an invalidate at most once, and only after receiving one. They also assume that `wb_done` comes only from a processor that was told to write back, and that the request fields hold steady while `req_valid` is high. The stimulus sends acknowledgements only on ports that received `cmd_inv`, and sends `wb_done` only on the commanded holder. The one exception is a deliberate acknowledgement from the requester itself, used to show that the counter masks it. Requests are raised only while `req_ready` is high and are dropped after one accepted cycle.

// File: rtl/fmap_dir_pkg.sv
package fmap_dir_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_INV  = 2'd1,
        ST_WB   = 2'd2
    } dir_state_e;

    function automatic int unsigned bitcount(input logic [63:0] v);
        int unsigned c;
        c = 0;
        for (int i = 0; i < 64; i++) begin
            c += int'(v[i]);
        end
        return c;
    endfunction

endpackage

// File: rtl/fmap_dir_store.sv
module fmap_dir_store #(
    parameter int N_PROC   = 4,
    parameter int N_BLOCKS = 16,
    parameter int ADDR_W   = $clog2(N_BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [N_PROC-1:0] rd_sh,
    output logic              rd_ex,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [N_PROC-1:0] wr_sh,
    input  logic              wr_ex
);

    logic [N_PROC-1:0] sh_q [N_BLOCKS];
    logic              ex_q [N_BLOCKS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < N_BLOCKS; b++) begin
                sh_q[b] <= '0;
                ex_q[b] <= 1'b0;
            end
        end else if (wr_en) begin
            sh_q[wr_addr] <= wr_sh;
            ex_q[wr_addr] <= wr_ex;
        end
    end

    assign rd_sh = sh_q[rd_addr];
    assign rd_ex = ex_q[rd_addr];

    AST_EXCL_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ex) |-> ($countones(wr_sh) == 1)); // R5

endmodule

// File: rtl/fmap_dir_ack_ctr.sv
module fmap_dir_ack_ctr
    import fmap_dir_pkg::*;
#(
    parameter int N_PROC = 4,
    localparam int CNT_W = $clog2(N_PROC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [N_PROC-1:0] load_mask,
    input  logic [N_PROC-1:0] ack,
    output logic              busy,
    output logic              last
);

    typedef struct packed {
        logic [N_PROC-1:0] pend;
        logic [CNT_W-1:0]  cnt;
    } ack_regs_t;

    ack_regs_t a_d, a_q;
    logic [N_PROC-1:0] hit_mask;
    logic [CNT_W-1:0]  hits;

    always_comb begin
        a_d      = a_q;
        hit_mask = ack & a_q.pend;
        hits     = CNT_W'(bitcount(64'(hit_mask)));
        if (load) begin
            a_d.pend = load_mask;
            a_d.cnt  = CNT_W'(bitcount(64'(load_mask)));
        end else if (|a_q.pend) begin
            a_d.pend = a_q.pend & ~ack;
            a_d.cnt  = a_q.cnt - hits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign busy = |a_q.pend;
    assign last = busy && (hits == a_q.cnt);

    AST_CNT_TRACKS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        a_q.cnt == CNT_W'($countones(a_q.pend))); // R4
    AST_NO_LOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy); // R8

endmodule

// File: rtl/fmap_dir_ctrl.sv
module fmap_dir_ctrl
    import fmap_dir_pkg::*;
#(
    parameter int N_PROC   = 4,
    parameter int N_BLOCKS = 16,
    localparam int PID_W   = $clog2(N_PROC),
    localparam int ADDR_W  = $clog2(N_BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_excl,
    input  logic [PID_W-1:0]  req_src,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [N_PROC-1:0] cmd_inv,
    output logic [N_PROC-1:0] cmd_wb,
    output logic [ADDR_W-1:0] cmd_addr,
    input  logic [N_PROC-1:0] inv_ack,
    input  logic [N_PROC-1:0] wb_done,
    output logic              grant_valid,
    output logic              grant_excl,
    output logic [PID_W-1:0]  grant_dst,
    output logic [ADDR_W-1:0] grant_addr
);

    localparam logic [N_PROC-1:0] ONE_HOT0 = N_PROC'(1);

    typedef struct packed {
        dir_state_e        st;
        logic [PID_W-1:0]  src;
        logic [ADDR_W-1:0] addr;
        logic [N_PROC-1:0] owner;
        logic [N_PROC-1:0] inv;
        logic [N_PROC-1:0] wb;
        logic              gnt;
        logic              gex;
        logic [PID_W-1:0]  gdst;
        logic [ADDR_W-1:0] gaddr;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;

    logic [N_PROC-1:0] rd_sh;
    logic              rd_ex;
    logic              st_we;
    logic [ADDR_W-1:0] st_waddr;
    logic [N_PROC-1:0] st_wsh;
    logic              st_wex;
    logic              ac_load;
    logic [N_PROC-1:0] ac_mask;
    logic              ac_busy;
    logic              ac_last;
    logic [N_PROC-1:0] req_oh;
    logic [N_PROC-1:0] held_oh;
    logic [N_PROC-1:0] others;
    logic              wb_hit;

    fmap_dir_store #(
        .N_PROC   (N_PROC),
        .N_BLOCKS (N_BLOCKS),
        .ADDR_W   (ADDR_W)
    ) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (req_addr),
        .rd_sh   (rd_sh),
        .rd_ex   (rd_ex),
        .wr_en   (st_we),
        .wr_addr (st_waddr),
        .wr_sh   (st_wsh),
        .wr_ex   (st_wex)
    );

    fmap_dir_ack_ctr #(
        .N_PROC (N_PROC)
    ) ackc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ac_load),
        .load_mask (ac_mask),
        .ack       (inv_ack),
        .busy      (ac_busy),
        .last      (ac_last)
    );

    always_comb begin
        r_d      = r_q;
        r_d.inv  = '0;
        r_d.wb   = '0;
        r_d.gnt  = 1'b0;
        st_we    = 1'b0;
        st_waddr = r_q.addr;
        st_wsh   = '0;
        st_wex   = 1'b0;
        ac_load  = 1'b0;
        ac_mask  = '0;
        req_oh   = ONE_HOT0 << req_src;
        held_oh  = ONE_HOT0 << r_q.src;
        others   = rd_sh & ~req_oh;
        wb_hit   = |(wb_done & r_q.owner);

        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.src   = req_src;
                    r_d.addr  = req_addr;
                    r_d.gdst  = req_src;
                    r_d.gaddr = req_addr;
                    st_waddr  = req_addr;
                    if (req_excl) begin
                        if (others == '0) begin
                            r_d.gnt = 1'b1;
                            r_d.gex = 1'b1;
                            st_we   = 1'b1;
                            st_wsh  = req_oh;
                            st_wex  = 1'b1;
                        end else begin
                            r_d.inv = others;
                            ac_load = 1'b1;
                            ac_mask = others;
                            r_d.st  = ST_INV;
                        end
                    end else if (rd_ex && (rd_sh != req_oh)) begin
                        r_d.wb    = rd_sh;
                        r_d.owner = rd_sh;
                        r_d.st    = ST_WB;
                    end else begin
                        r_d.gnt = 1'b1;
                        r_d.gex = 1'b0;
                        if (!rd_ex) begin
                            st_we  = 1'b1;
                            st_wsh = rd_sh | req_oh;
                            st_wex = 1'b0;
                        end
                    end
                end
            end
            ST_INV: begin
                if (ac_last) begin
                    r_d.gnt = 1'b1;
                    r_d.gex = 1'b1;
                    st_we   = 1'b1;
                    st_wsh  = held_oh;
                    st_wex  = 1'b1;
                    r_d.st  = ST_IDLE;
                end
            end
            ST_WB: begin
                if (wb_hit) begin
                    r_d.gnt = 1'b1;
                    r_d.gex = 1'b0;
                    st_we   = 1'b1;
                    st_wsh  = r_q.owner | held_oh;
                    st_wex  = 1'b0;
                    r_d.st  = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign req_ready   = (r_q.st == ST_IDLE);
    assign cmd_inv     = r_q.inv;
    assign cmd_wb      = r_q.wb;
    assign cmd_addr    = r_q.addr;
    assign grant_valid = r_q.gnt;
    assign grant_excl  = r_q.gex;
    assign grant_dst   = r_q.gdst;
    assign grant_addr  = r_q.gaddr;

    AST_READY_LOW_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        ((|cmd_inv) || (|cmd_wb)) |-> !req_ready); // R8
    AST_INV_SKIPS_REQUESTER: assert property (@(posedge clk) disable iff (!rst_n)
        (|cmd_inv) |-> (cmd_inv[r_q.src] == 1'b0)); // R9
    AST_NO_EARLY_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_INV && !ac_last) |=> !grant_valid); // R4
    AST_INV_WAIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_INV) |-> ac_busy); // R4
    AST_WB_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (|cmd_wb) |-> ($countones(cmd_wb) == 1)); // R6
    AST_WB_GRANT_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WB && wb_hit) |=> (grant_valid && !grant_excl)); // R7

endmodule

// File: tb/fmap_dir_ctrl_tb.sv
module fmap_dir_ctrl_tb_top;

    localparam int N  = 4;
    localparam int NB = 16;
    localparam int PW = 2;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_excl = 1'b0;
    logic [PW-1:0] req_src = '0;
    logic [AW-1:0] req_addr = '0;
    logic [N-1:0]  cmd_inv;
    logic [N-1:0]  cmd_wb;
    logic [AW-1:0] cmd_addr;
    logic [N-1:0]  inv_ack = '0;
    logic [N-1:0]  wb_done = '0;
    logic          grant_valid;
    logic          grant_excl;
    logic [PW-1:0] grant_dst;
    logic [AW-1:0] grant_addr;

    always #10 clk = ~clk;

    fmap_dir_ctrl #(.N_PROC(N), .N_BLOCKS(NB)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_excl(req_excl),
        .req_src(req_src), .req_addr(req_addr),
        .cmd_inv(cmd_inv), .cmd_wb(cmd_wb), .cmd_addr(cmd_addr),
        .inv_ack(inv_ack), .wb_done(wb_done),
        .grant_valid(grant_valid), .grant_excl(grant_excl),
        .grant_dst(grant_dst), .grant_addr(grant_addr)
    );

    int tests = 0;
    int fails = 0;

    logic [N-1:0] m_sh [NB];
    logic         m_ex [NB];

    logic          exp_ready;
    logic [N-1:0]  exp_inv;
    logic [N-1:0]  exp_wb;
    logic [AW-1:0] exp_caddr;
    logic          exp_gnt;
    logic          exp_gex;
    logic [PW-1:0] exp_gdst;
    logic [AW-1:0] exp_gaddr;
    string         tag;

    task automatic compare();
        logic bad;
        tests++;
        bad = (req_ready !== exp_ready) || (cmd_inv !== exp_inv) ||
              (cmd_wb !== exp_wb) || (grant_valid !== exp_gnt);
        if ((exp_inv != '0 || exp_wb != '0) && cmd_addr !== exp_caddr) bad = 1'b1;
        if (exp_gnt && (grant_excl !== exp_gex || grant_dst !== exp_gdst ||
                        grant_addr !== exp_gaddr)) bad = 1'b1;
        if (bad) begin
            fails++;
            $display("FAIL %s: got ready=%0b inv=%b wb=%b caddr=%0d gnt=%0b gex=%0b gdst=%0d gaddr=%0d, expected ready=%0b inv=%b wb=%b caddr=%0d gnt=%0b gex=%0b gdst=%0d gaddr=%0d",
                     tag, req_ready, cmd_inv, cmd_wb, cmd_addr, grant_valid,
                     grant_excl, grant_dst, grant_addr, exp_ready, exp_inv,
                     exp_wb, exp_caddr, exp_gnt, exp_gex, exp_gdst, exp_gaddr);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        compare();
    endtask

    task automatic clear_pulses();
        exp_inv = '0;
        exp_wb  = '0;
        exp_gnt = 1'b0;
    endtask

    task automatic expect_grant(input bit ex, input int src, input int blk);
        exp_gnt   = 1'b1;
        exp_gex   = ex;
        exp_gdst  = PW'(src);
        exp_gaddr = AW'(blk);
        exp_ready = 1'b1;
    endtask

    task automatic txn(input bit ex, input int src, input int blk,
                       input bit serial, input bit stray);
        logic [N-1:0] sb;
        logic [N-1:0] others;
        logic [N-1:0] owner;
        logic [N-1:0] left;
        sb        = N'(1) << src;
        others    = m_sh[blk] & ~sb;
        owner     = m_sh[blk];
        exp_caddr = AW'(blk);
        req_valid = 1'b1;
        req_excl  = ex;
        req_src   = PW'(src);
        req_addr  = AW'(blk);
        clear_pulses();
        if (ex && others == '0) begin
            tag = "R9 exclusive with no other sharer";
            expect_grant(1'b1, src, blk);
            tick();
            req_valid = 1'b0;
            m_sh[blk] = sb;
            m_ex[blk] = 1'b1;
        end else if (ex) begin
            tag = "R3 invalidate fan-out";
            exp_inv   = others;
            exp_ready = 1'b0;
            tick();
            req_valid = 1'b0;
            clear_pulses();
            tag = "R4 waiting for acks";
            tick();
            if (stray) begin
                tag = "R10 stray ack ignored";
                inv_ack = sb;
                tick();
                inv_ack = '0;
            end
            left = others;
            if (serial) begin
                for (int i = 0; i < N; i++) begin
                    if (others[i]) begin
                        left[i] = 1'b0;
                        inv_ack = N'(1) << i;
                        if (left == '0) begin
                            tag = "R4 grant after last serial ack";
                            expect_grant(1'b1, src, blk);
                        end else begin
                            tag = "R4 partial acks";
                        end
                        tick();
                        inv_ack = '0;
                    end
                end
            end else begin
                tag = "R4 grant after joint acks";
                inv_ack = others;
                expect_grant(1'b1, src, blk);
                tick();
                inv_ack = '0;
            end
            m_sh[blk] = sb;
            m_ex[blk] = 1'b1;
        end else if (m_ex[blk] && m_sh[blk] != sb) begin
            tag = "R6 write-back command";
            exp_wb    = owner;
            exp_ready = 1'b0;
            tick();
            req_valid = 1'b0;
            clear_pulses();
            tag = "R8 stalled during write-back";
            tick();
            tag = "R7 shared grant after write-back";
            wb_done = owner;
            expect_grant(1'b0, src, blk);
            tick();
            wb_done   = '0;
            m_sh[blk] = owner | sb;
            m_ex[blk] = 1'b0;
        end else begin
            if (m_ex[blk]) tag = "R11 holder rereads";
            else           tag = "R2 shared read";
            expect_grant(1'b0, src, blk);
            tick();
            req_valid = 1'b0;
            if (!m_ex[blk]) m_sh[blk] = m_sh[blk] | sb;
        end
        tag = "R8 grant pulse ends, ready held";
        clear_pulses();
        exp_ready = 1'b1;
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int b = 0; b < NB; b++) begin
            m_sh[b] = '0;
            m_ex[b] = 1'b0;
        end
        exp_ready = 1'b1;
        exp_caddr = '0;
        exp_gex   = 1'b0;
        exp_gdst  = '0;
        exp_gaddr = '0;
        clear_pulses();
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        tag = "R1 reset state";
        tick();
        tick();

        // R2: three readers gather on block 3
        txn(1'b0, 0, 3, 1'b0, 1'b0);
        txn(1'b0, 1, 3, 1'b0, 1'b0);
        txn(1'b0, 2, 3, 1'b0, 1'b0);
        // R3 R9 R10 R4: P1 upgrades, P0 and P2 invalidated, stray ack from P1
        txn(1'b1, 1, 3, 1'b1, 1'b1);
        // R6 R7: P3 reads while P1 holds for writing
        txn(1'b0, 3, 3, 1'b0, 1'b0);
        // R5 R7: P0 upgrade must invalidate exactly P1 and P3
        txn(1'b1, 0, 3, 1'b0, 1'b0);
        // R11: holder rereads, then P2 read proves it still holds it
        txn(1'b0, 0, 3, 1'b0, 1'b0);
        txn(1'b0, 2, 3, 1'b0, 1'b0);
        // R9: exclusive on empty block, then again with only own bit set
        txn(1'b1, 2, 5, 1'b0, 1'b0);
        txn(1'b1, 2, 5, 1'b0, 1'b0);
        // R5: other processor takes the block from the single holder
        txn(1'b1, 1, 5, 1'b1, 1'b0);
        // R2 on the last block index
        txn(1'b0, 3, NB - 1, 1'b0, 1'b0);

        for (int k = 0; k < 150; k++) begin
            txn(1'($urandom % 2), int'($urandom % N), int'($urandom % 3),
                1'($urandom % 2), 1'($urandom % 4 == 0));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule